// File: doc/BRIEF.md
# Up-Counting Timer Channel with Compare Waveform

This block is a single channel of a general-purpose timer. A counter advances by one per clock while the run bit is set. It counts from zero up to a programmed reload value inclusive and then returns to zero, so one period lasts reload+1 clocks. Software programs the reload and compare values as the wanted count minus one. Two compare values share one waveform output. That output starts every period at a programmed polarity and inverts after each compare match. Optionally the counter can stop for good at the reload point instead of wrapping.

The counter can be forced to zero and held there, or loaded once from a preset register. It can also restart from three sources: a selected edge of an external synchronisation input, a per-channel software pulse, or the restart pulse of the neighbouring channel. Each restart is passed on through the channel's own restart output, so channels can be chained. The channel produces single-cycle event flags that an outer status register accumulates. It also produces a DMA request pulse whose source is selectable. All configuration arrives through a small write-only register port.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `cnt_o`, `cmp_out_o`, `flags_o`, `dma_req_o` and `sync_out_o` are all zero.
- R2: With run (control bit 0) set, the count shown after each clock is one above the previous one. After the edge where the count equals the reload register (address 1), it becomes 0. With run clear, the count holds.
- R3: `flags_o` carries one-cycle pulses, visible in the cycle after the one in which the advancing counter equalled the value concerned. Bit 0 is the reload match, bit 2 is the compare-0 match (address 2) and bit 3 is the compare-1 match (address 3). Bit 1, the capture position, is always 0.
- R4: The waveform level equals the polarity bit (control bit 2) while the count is 0. It inverts once for each compare value that the count has passed, so for count c it equals pol XOR (c>cmp0) XOR (c>cmp1). `cmp_out_o` shows this level only while output enable (control bit 1) is set; otherwise it is 0.
- R5: With one-shot (control bit 3) set, the counter stops at the reload value. The reload flag pulses exactly once, and the count stays there until a clear, restart or load.
- R6: While clear (control bit 4) is set, the count is held at 0. Writing control with load (bit 5) set copies the preset register (address 4) into the counter one clock after the write. Load is a strobe and is never held. The priority is clear, then restart, then load, then counting.
- R7: A restart forces the count to 0 and pulses `sync_out_o` in the cycle after. A restart comes from a rising edge of `sync_in` when bit 6 is set, a falling edge when bit 7 is set, a `sw_sync` pulse, or a `prev_sync` pulse when follow (bit 8) is set. Edges that are not enabled, and `prev_sync` while follow is clear, have no effect.
- R8: When a restart coincides with the reload point, the restart wins: the count goes to 0 and the reload flag still pulses. In one-shot mode the counter does not halt in that case.
- R9: With DMA enable (bit 9) set, `dma_req_o` pulses together with the event chosen by control bits 11:10: 0 = compare-0 match, 1 = compare-1 match, 2 = any change of `sync_in`, 3 = reload match. With DMA enable clear, it stays 0.
- R10: While debug freeze enable (bit 12) is set and `dbg_halt` is high, the counter holds. With bit 12 clear, `dbg_halt` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1 reload, 2 compare 0, 3 compare 1, 4 preset |
| cfg_wdata | input | DW | Write data |
| sync_in | input | 1 | External synchronisation level |
| sw_sync | input | 1 | Software restart pulse for this channel |
| prev_sync | input | 1 | Restart pulse from the neighbouring channel |
| dbg_halt | input | 1 | Debug halt request |
| cnt_o | output | CW | Current count |
| cmp_out_o | output | 1 | Compare waveform |
| flags_o | output | 4 | Event pulses for the outer status register |
| dma_req_o | output | 1 | DMA request pulse |
| sync_out_o | output | 1 | Pulse when this channel restarted |

## Verification
The bench builds the channel with an 8-bit counter and a 16-bit write bus. This makes the largest reload value, 255, a full period of only 256 clocks, so wrapping at the top of the counter range is exercised alongside short random periods. The wider bus also holds the 13-bit control word. Random reload, compare, polarity, output-enable and DMA-source settings include compares equal to each other, to zero and to the reload value. Directed sequences cover restart edges, chaining, the restart-at-reload collision in one-shot mode, freeze, clear and preset loading.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 4;
  localparam int FL_RELOAD = 0;
  localparam int FL_CAPT   = 1;
  localparam int FL_CMP0   = 2;
  localparam int FL_CMP1   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_RLD  = 3'd1,
    A_CMP0 = 3'd2,
    A_CMP1 = 3'd3,
    A_PRE  = 3'd4
  } addr_e;

  typedef enum logic [1:0] {
    DS_CMP0   = 2'd0,
    DS_CMP1   = 2'd1,
    DS_TOGGLE = 2'd2,
    DS_RELOAD = 2'd3
  } dma_src_e;

  // Packed from MSB (bit 12) down to LSB (bit 0)
  typedef struct packed {
    logic     frz_en;
    dma_src_e dma_src;
    logic     dma_en;
    logic     follow;
    logic     fall_en;
    logic     rise_en;
    logic     load;
    logic     clr;
    logic     one_shot;
    logic     pol;
    logic     out_en;
    logic     run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     rld_o,
  output logic [CW-1:0]     cmp0_o,
  output logic [CW-1:0]     cmp1_o,
  output logic [CW-1:0]     pre_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] rld_q, rld_d, cmp0_q, cmp0_d, cmp1_q, cmp1_d, pre_q, pre_d;
  logic          wr_ctrl;

  assign wr_ctrl = we && (addr == A_CTRL);

  always_comb begin
    ctrl_d      = ctrl_q;
    ctrl_d.load = 1'b0;
    rld_d       = rld_q;
    cmp0_d      = cmp0_q;
    cmp1_d      = cmp1_q;
    pre_d       = pre_q;
    if (we) begin
      unique case (addr)
        A_CTRL:  ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        A_RLD:   rld_d  = wdata[CW-1:0];
        A_CMP0:  cmp0_d = wdata[CW-1:0];
        A_CMP1:  cmp1_d = wdata[CW-1:0];
        A_PRE:   pre_d  = wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '1;
      cmp0_q <= '1;
      cmp1_q <= '1;
      pre_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rld_q  <= rld_d;
      cmp0_q <= cmp0_d;
      cmp1_q <= cmp1_d;
      pre_q  <= pre_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign rld_o  = rld_q;
  assign cmp0_o = cmp0_q;
  assign cmp1_o = cmp1_q;
  assign pre_o  = pre_q;

  // R6: load is a one-cycle strobe
  p_load_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.load && !wr_ctrl) |=> !ctrl_q.load);
endmodule

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync
  import tmr_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic rise_en,
  input  logic fall_en,
  input  logic sw_sync,
  input  logic follow,
  input  logic prev_sync,
  output logic restart_o,
  output logic toggle_o
);
  logic sync_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign rise      = sync_in && !sync_q;
  assign fall      = !sync_in && sync_q;
  assign toggle_o  = sync_in ^ sync_q;
  assign restart_o = (rise && rise_en) || (fall && fall_en) || sw_sync || (follow && prev_sync);

  // R7: a disabled edge source alone never restarts
  p_edge_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && !sw_sync && !(follow && prev_sync)) |-> (rise_en || fall_en));
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CW-1:0]    rld,
  input  logic [CW-1:0]    cmp0,
  input  logic [CW-1:0]    cmp1,
  input  logic [CW-1:0]    pre,
  input  logic             restart,
  input  logic             toggle,
  input  logic             dbg_halt,
  output logic [CW-1:0]    cnt_o,
  output logic             lvl_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             dma_req_o,
  output logic             sync_out_o
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             lvl_q, lvl_d;
  logic [NFLAG-1:0] flag_q, flag_d;
  logic             dma_q, dma_d;
  logic             sout_q;
  logic             frozen, adv, hit_rld, hit0, hit1;

  assign frozen  = ctrl.frz_en && dbg_halt;
  assign adv     = ctrl.run && !frozen && !done_q && !ctrl.clr;
  assign hit_rld = adv && (cnt_q == rld);
  assign hit0    = adv && (cnt_q == cmp0);
  assign hit1    = adv && (cnt_q == cmp1);

  // counter and one-shot state, priority clear > restart > load > count
  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (ctrl.clr || restart) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (ctrl.load) begin
      cnt_d  = pre;
      done_d = 1'b0;
    end else if (adv) begin
      if (hit_rld) begin
        if (ctrl.one_shot) done_d = 1'b1;
        else               cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  // waveform level
  always_comb begin
    lvl_d = lvl_q;
    if (ctrl.clr || restart || !ctrl.run || hit_rld) lvl_d = ctrl.pol;
    else if (hit0 ^ hit1)                            lvl_d = !lvl_q;
  end

  // event pulses
  always_comb begin
    flag_d           = '0;
    flag_d[FL_RELOAD] = hit_rld;
    flag_d[FL_CMP0]   = hit0;
    flag_d[FL_CMP1]   = hit1;
    unique case (ctrl.dma_src)
      DS_CMP0:   dma_d = hit0;
      DS_CMP1:   dma_d = hit1;
      DS_TOGGLE: dma_d = toggle;
      default:   dma_d = hit_rld;
    endcase
    dma_d = dma_d && ctrl.dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      lvl_q  <= 1'b0;
      flag_q <= '0;
      dma_q  <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
      dma_q  <= dma_d;
      sout_q <= restart;
    end
  end

  assign cnt_o      = cnt_q;
  assign lvl_o      = lvl_q;
  assign flags_o    = flag_q;
  assign dma_req_o  = dma_q;
  assign sync_out_o = sout_q;

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.clr && !restart && !ctrl.load) |=> $stable(cnt_q));
  p_oneshot_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctrl.clr && !restart && !ctrl.load) |=> $stable(cnt_q));
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clr |=> (cnt_q == '0));
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ctrl.clr) |=> (cnt_q == '0) && sync_out_o);
  p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rld && restart) |=> flag_q[FL_RELOAD] && !done_q && (cnt_q == '0));
  p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> $past(ctrl.dma_en));
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ctrl.clr && !restart && !ctrl.load) |=> $stable(cnt_q));
  p_capt_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q[FL_CAPT]);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             sync_in,
  input  logic             sw_sync,
  input  logic             prev_sync,
  input  logic             dbg_halt,
  output logic [CW-1:0]    cnt_o,
  output logic             cmp_out_o,
  output logic [3:0]       flags_o,
  output logic             dma_req_o,
  output logic             sync_out_o
);
  logic [1:0]    rst_pipe;
  logic          rst_ni;
  ctrl_t         ctrl;
  logic [CW-1:0] rld, cmp0, cmp1, pre;
  logic          restart, toggle, lvl;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  tmr_chan_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl_o(ctrl), .rld_o(rld), .cmp0_o(cmp0), .cmp1_o(cmp1), .pre_o(pre)
  );

  tmr_chan_sync u_sync (
    .clk(clk), .rst_n(rst_ni), .sync_in(sync_in),
    .rise_en(ctrl.rise_en), .fall_en(ctrl.fall_en), .sw_sync(sw_sync),
    .follow(ctrl.follow), .prev_sync(prev_sync),
    .restart_o(restart), .toggle_o(toggle)
  );

  tmr_chan_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_ni), .ctrl(ctrl), .rld(rld), .cmp0(cmp0), .cmp1(cmp1),
    .pre(pre), .restart(restart), .toggle(toggle), .dbg_halt(dbg_halt),
    .cnt_o(cnt_o), .lvl_o(lvl), .flags_o(flags_o), .dma_req_o(dma_req_o),
    .sync_out_o(sync_out_o)
  );

  assign cmp_out_o = lvl && ctrl.out_en;

  // R4: output is silent while disabled
  p_out_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_out_o |-> ctrl.out_en);
endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int C_RUN = 1 << 0, C_OE = 1 << 1, C_POL = 1 << 2, C_OS = 1 << 3;
  localparam int C_CLR = 1 << 4, C_LD = 1 << 5, C_RISE = 1 << 6, C_FALL = 1 << 7;
  localparam int C_FOL = 1 << 8, C_DEN = 1 << 9, C_FRZ = 1 << 12;

  logic clk = 1'b0;
  logic rst_n, cfg_we, sync_in, sw_sync, prev_sync, dbg_halt;
  logic [2:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [CW-1:0] cnt_o;
  logic cmp_out_o, dma_req_o, sync_out_o;
  logic [3:0] flags_o;
  int checks = 0;
  int fails = 0;

  always #2 clk = !clk;

  tmr_chan #(.CW(CW), .DW(DW)) u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sync_in(sync_in), .sw_sync(sw_sync), .prev_sync(prev_sync), .dbg_halt(dbg_halt),
    .cnt_o(cnt_o), .cmp_out_o(cmp_out_o), .flags_o(flags_o), .dma_req_o(dma_req_o),
    .sync_out_o(sync_out_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_addr = a[2:0]; cfg_wdata = d[DW-1:0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(input int w);
    wr(0, (w & ~C_RUN) | C_CLR);
    wr(0, w);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_lvl(int c, int c0, int c1, int pol, int oe);
    return oe & (pol ^ int'(c > c0) ^ int'(c > c1));
  endfunction

  function automatic int exp_flags(int p, int r, int c0, int c1);
    if (p < 0) return 0;
    return (int'(p == c1) << 3) | (int'(p == c0) << 2) | int'(p == r);
  endfunction

  function automatic int exp_dma(int p, int r, int c0, int c1, int sel);
    if (p < 0) return 0;
    case (sel)
      0: return int'(p == c0);
      1: return int'(p == c1);
      3: return int'(p == r);
      default: return 0;
    endcase
  endfunction

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, nrl;
    void'($urandom(32'h5eed1));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sync_in = 1'b0; sw_sync = 1'b0; prev_sync = 1'b0; dbg_halt = 1'b0;
    step(3); rst_n = 1'b1; step(3);
    // R1 reset values
    chk("R1 cnt", cnt_o, 0); chk("R1 cmp_out", cmp_out_o, 0);
    chk("R1 flags", flags_o, 0); chk("R1 dma", dma_req_o, 0); chk("R1 sync_out", sync_out_o, 0);

    // Random periods: R2, R3, R4, R9
    for (int it = 0; it < 8; it++) begin
      int r, c0, c1, pol, oe, sel, prev;
      r   = (it == 0) ? 255 : 2 + int'($urandom % 39);
      c0  = int'($urandom % (r + 1));
      c1  = (it == 1) ? c0 : ((it == 2) ? r : int'($urandom % (r + 1)));
      pol = int'($urandom % 2); oe = (it == 3) ? 0 : int'($urandom % 2);
      sel = int'($urandom % 4);
      wr(1, r); wr(2, c0); wr(3, c1);
      start(C_RUN | (oe ? C_OE : 0) | (pol ? C_POL : 0) | C_DEN | (sel << 10));
      prev = -1;
      for (int k = 0; k < 2 * (r + 1) + 3; k++) begin
        int e;
        e = k % (r + 1);
        chk("R2 count", cnt_o, e);
        chk("R4 waveform", cmp_out_o, exp_lvl(e, c0, c1, pol, oe));
        chk("R3 flags", flags_o, exp_flags(prev, r, c0, c1));
        chk("R9 dma", dma_req_o, exp_dma(prev, r, c0, c1, sel));
        prev = e;
        step(1);
      end
    end

    // R6 load and R2 hold while stopped
    wr(4, 77);
    start(0);
    wr(0, C_LD);
    chk("R2 hold while stopped", cnt_o, 0);
    step(1); chk("R6 preset load", cnt_o, 77);
    step(2); chk("R6 load is a strobe", cnt_o, 77);
    // R6 clear holds zero while running
    wr(0, C_RUN | C_CLR);
    step(1); chk("R6 clear", cnt_o, 0);
    step(3); chk("R6 clear held", cnt_o, 0);

    // R7 sync edges
    wr(1, 200);
    start(C_RUN | C_RISE);
    step(10); chk("R7 pre-edge count", cnt_o, 10);
    sync_in = 1'b1; step(1);
    chk("R7 rising restart", cnt_o, 0); chk("R7 sync_out", sync_out_o, 1);
    step(4); c = cnt_o;
    sync_in = 1'b0; step(1);
    chk("R7 falling ignored", cnt_o, c + 1); chk("R7 no sync_out", sync_out_o, 0);
    wr(0, C_RUN | C_FALL);
    c = cnt_o; sync_in = 1'b1; step(1);
    chk("R7 rising ignored", cnt_o, c + 1);
    step(3); sync_in = 1'b0; step(1);
    chk("R7 falling restart", cnt_o, 0);
    step(5); sw_sync = 1'b1; step(1); sw_sync = 1'b0;
    chk("R7 software restart", cnt_o, 0); chk("R7 software sync_out", sync_out_o, 1);
    step(5); c = cnt_o; prev_sync = 1'b1; step(1); prev_sync = 1'b0;
    chk("R7 follow off ignored", cnt_o, c + 1);
    wr(0, C_RUN | C_FOL);
    step(2); prev_sync = 1'b1; step(1); prev_sync = 1'b0;
    chk("R7 follow restart", cnt_o, 0);

    // R8 restart at reload in one-shot, then R5 halt
    wr(1, 5);
    start(C_RUN | C_OS);
    step(5); chk("R8 at reload", cnt_o, 5);
    sw_sync = 1'b1; step(1); sw_sync = 1'b0;
    chk("R8 restart wins", cnt_o, 0); chk("R8 reload flag", flags_o & 1, 1);
    step(1); chk("R8 not halted", cnt_o, 1);
    nrl = 0;
    for (int k = 0; k < 20; k++) begin step(1); nrl += flags_o[0]; end
    chk("R5 stops at reload", cnt_o, 5);
    chk("R5 single reload flag", nrl, 1);

    // R10 debug freeze
    wr(1, 200);
    start(C_RUN | C_FRZ);
    step(6); c = cnt_o; dbg_halt = 1'b1;
    step(3); chk("R10 frozen", cnt_o, c);
    dbg_halt = 1'b0; step(1); chk("R10 resumes", cnt_o, c + 1);
    wr(0, C_RUN);
    c = cnt_o; dbg_halt = 1'b1; step(2);
    chk("R10 halt ignored", cnt_o, c + 2);
    dbg_halt = 1'b0;

    // R9 toggle source and enable gate
    wr(0, C_RUN | C_DEN | (2 << 10));
    step(2); sync_in = 1'b1; step(1);
    chk("R9 toggle request", dma_req_o, 1);
    step(1); chk("R9 toggle pulse ends", dma_req_o, 0);
    wr(0, C_RUN | (2 << 10));
    sync_in = 1'b0; step(1);
    chk("R9 disabled request", dma_req_o, 0);

    summary();
    $finish;
  end
endmodule